// File: doc/BRIEF.md
# Conformance Test Step Player

This block runs a stored conformance test against a cyclic-scan controller. Steps are read in order from a step memory. For each step the block checks that the step chains onto the one before it, then drives the step's whole input combination onto the controller's inputs in a single clock. It holds that combination for an observation window measured in controller scan periods, and records one sample of the controller outputs per scan period into an observation buffer.

When the window closes, the block presents the buffer, the sample count and the step context (source state, input, destination state, expected output, and the inputs that were applied before) to an external verdict unit. It then waits for that unit's answer. A pass moves on to the next step. A fail, a chaining error or the end of the list stops the run and raises done, with fail set where the run did not pass.

The window never drops below the length that a step needs. A step that stays in the same state needs two scans. A step that changes state needs three, so that the self-loop on the destination is also seen. Tolerant mode, which allows for intermediate input combinations, needs four. The window is also capped at the buffer depth (parameter OBS_DEPTH, at least 4).

Top module: `tsx_step_player`

## Requirements
- R1: After reset, dut_in is zero and busy, done, fail, chain_err and chk_valid are all low.
- R2: A start pulse seen while idle or finished latches num_steps, init_state, scan_len, win_scans and tolerant, raises busy and clears done, fail and chain_err. The block then reads steps at step_addr 0, 1, 2 and so on. A step word is, from MSB to LSB: source state (ST_W), input combination (IN_W), destination state (ST_W), expected output (OUT_W).
- R3: All bits of a step's input combination appear on dut_in in the same clock, one clock after that step's address is presented. They stay unchanged until the next step is applied.
- R4: The window length is max(win_scans, F) limited to OBS_DEPTH. F is 4 when tolerant is set, otherwise 3 when source and destination differ, otherwise 2. chk_count reports this length.
- R5: A scan period lasts scan_len clocks, and a value of 0 acts as 1. On the last clock of scan k of the window, dut_out is stored in slot k, which is chk_obs bits [k*OUT_W +: OUT_W]. Slots beyond the window read zero.
- R6: chk_valid rises on the clock after the final sample is taken. It stays high, with chk_obs and the step context unchanged, until vrd_valid is seen.
- R7: The first step's source state must equal init_state, and every later step's source must equal the previous step's destination. On a mismatch the step is not applied: dut_in keeps its value, chain_err, fail and done go high, and busy drops.
- R8: A passing verdict on the last step raises done with fail low and drops busy. A passing verdict on any other step loads the next one.
- R9: A failing verdict raises done and fail, and no further step is read or applied.
- R10: A start with num_steps equal to 0 raises done one clock later without changing dut_in.
- R11: chk_prev_in shows the value dut_in held before the current step was applied.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run |
| num_steps | input | ADDR_W+1 | Number of steps in the run |
| init_state | input | ST_W | State the first step must start from |
| scan_len | input | SCAN_W | Clocks per controller scan period |
| win_scans | input | WIN_W | Requested window length in scans |
| tolerant | input | 1 | Tolerant mode, which lengthens the window |
| step_addr | output | ADDR_W | Step memory address |
| step_word | input | 2*ST_W+IN_W+OUT_W | Step memory data for step_addr, read combinationally |
| dut_in | output | IN_W | Inputs driven to the controller |
| dut_out | input | OUT_W | Outputs read from the controller |
| chk_valid | output | 1 | Window complete, waiting for a verdict |
| chk_obs | output | OBS_DEPTH*OUT_W | Observation buffer |
| chk_count | output | clog2(OBS_DEPTH+1) | Number of samples in the window |
| chk_up | output | ST_W | Current step's source state |
| chk_in | output | IN_W | Current step's input combination |
| chk_down | output | ST_W | Current step's destination state |
| chk_exp | output | OUT_W | Current step's expected output |
| chk_prev_in | output | IN_W | Inputs held before the current step |
| vrd_valid | input | 1 | Verdict available |
| vrd_pass | input | 1 | Verdict is positive |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Run finished without passing |
| chain_err | output | 1 | Run stopped on a chaining mismatch |

## Verification
The final sample of a window and the closing of that window happen on the same clock edge. Capturing one clock early or late, or closing the window one scan early or late, would hand the verdict unit the wrong data. The bench drives dut_out with a value that changes every clock, so each stored sample identifies the exact clock it came from. The reference model predicts the buffer contents and the cycle on which chk_valid rises, for scan lengths of 0, 1, 2 and 3. It also covers windows that are raised to the minimum and windows that are cut to the buffer depth.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_OBSERVE,
    PH_VERDICT,
    PH_END
  } tsx_phase_e;

  // Window length in scans: raise the request to the step's minimum, then cap it at the buffer depth.
  function automatic int unsigned tsx_window(input int unsigned req, input bit tol,
                                             input bit moves, input int unsigned depth);
    int unsigned floor_s;
    int unsigned w;
    floor_s = tol ? 4 : (moves ? 3 : 2);
    w = (req > floor_s) ? req : floor_s;
    return (w > depth) ? depth : w;
  endfunction

  // Last tick index of a scan period; a programmed length of zero acts as one clock.
  function automatic int unsigned tsx_tick_limit(input int unsigned scan_len);
    return (scan_len == 0) ? 0 : scan_len - 1;
  endfunction

endpackage

// File: rtl/tsx_window_calc.sv
module tsx_window_calc #(
  parameter int WIN_W = 4,
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input  logic [WIN_W-1:0] req,
  input  logic             tol,
  input  logic             moves,
  output logic [CNT_W-1:0] win
);
  import tsx_pkg::*;

  always_comb win = CNT_W'(tsx_window(32'(req), tol, moves, DEPTH));

endmodule

// File: rtl/tsx_scan_timer.sv
module tsx_scan_timer #(
  parameter int SCAN_W = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [SCAN_W-1:0] scan_len,
  input  logic [CNT_W-1:0]  win,
  output logic              sample_ev,
  output logic              last_ev,
  output logic [CNT_W-1:0]  scan_idx
);
  import tsx_pkg::*;

  logic [SCAN_W-1:0] tick_q;
  logic [SCAN_W-1:0] lim;

  always_comb lim = SCAN_W'(tsx_tick_limit(32'(scan_len)));

  assign sample_ev = run && (tick_q == lim);
  assign last_ev   = sample_ev && (scan_idx == CNT_W'(win - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      scan_idx <= '0;
    end else if (clear) begin
      tick_q   <= '0;
      scan_idx <= '0;
    end else if (run) begin
      if (sample_ev) begin
        tick_q <= '0;
        if (!last_ev) scan_idx <= scan_idx + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tsx_obs_buffer.sv
module tsx_obs_buffer #(
  parameter int OUT_W = 3,
  parameter int DEPTH = 6,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [OUT_W-1:0]       wr_data,
  output logic [DEPTH*OUT_W-1:0] flat
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [OUT_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q <= '0;
      else if (clear)                            slot_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))     slot_q <= wr_data;
    end
    assign flat[g*OUT_W +: OUT_W] = slot_q;
  end

endmodule

// File: rtl/tsx_step_player.sv
module tsx_step_player #(
  parameter int IN_W      = 4,
  parameter int OUT_W     = 3,
  parameter int ST_W      = 3,
  parameter int ADDR_W    = 4,
  parameter int OBS_DEPTH = 6,
  parameter int SCAN_W    = 4,
  parameter int WIN_W     = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [ADDR_W:0]                num_steps,
  input  logic [ST_W-1:0]                init_state,
  input  logic [SCAN_W-1:0]              scan_len,
  input  logic [WIN_W-1:0]               win_scans,
  input  logic                           tolerant,
  output logic [ADDR_W-1:0]              step_addr,
  input  logic [2*ST_W+IN_W+OUT_W-1:0]   step_word,
  output logic [IN_W-1:0]                dut_in,
  input  logic [OUT_W-1:0]               dut_out,
  output logic                           chk_valid,
  output logic [OBS_DEPTH*OUT_W-1:0]     chk_obs,
  output logic [$clog2(OBS_DEPTH+1)-1:0] chk_count,
  output logic [ST_W-1:0]                chk_up,
  output logic [IN_W-1:0]                chk_in,
  output logic [ST_W-1:0]                chk_down,
  output logic [OUT_W-1:0]               chk_exp,
  output logic [IN_W-1:0]                chk_prev_in,
  input  logic                           vrd_valid,
  input  logic                           vrd_pass,
  output logic                           busy,
  output logic                           done,
  output logic                           fail,
  output logic                           chain_err
);
  import tsx_pkg::*;

  localparam int STEP_W = 2*ST_W + IN_W + OUT_W;
  localparam int CNT_W  = $clog2(OBS_DEPTH+1);

  tsx_phase_e        phase_q;
  logic [ADDR_W:0]   idx_q, num_q;
  logic [ST_W-1:0]   prev_down_q;
  logic [SCAN_W-1:0] slen_q;
  logic [WIN_W-1:0]  wreq_q;
  logic              tol_q;
  logic [CNT_W-1:0]  win_q, win_next;

  // Step word fields, MSB first: source, input, destination, expected output.
  logic [ST_W-1:0]  w_up, w_dn;
  logic [IN_W-1:0]  w_in;
  logic [OUT_W-1:0] w_exp;
  assign w_up  = step_word[STEP_W-1 -: ST_W];
  assign w_in  = step_word[OUT_W+ST_W +: IN_W];
  assign w_dn  = step_word[OUT_W +: ST_W];
  assign w_exp = step_word[0 +: OUT_W];

  // Named events, also used by the bound checker.
  logic start_take, chain_bad, step_issue, verdict_take, sample_ev, last_ev;
  logic [CNT_W-1:0] scan_idx;

  assign start_take   = start && (phase_q == PH_IDLE || phase_q == PH_END);
  assign chain_bad    = (phase_q == PH_LOAD) && (w_up != prev_down_q);
  assign step_issue   = (phase_q == PH_LOAD) && (w_up == prev_down_q);
  assign verdict_take = (phase_q == PH_VERDICT) && vrd_valid;

  tsx_window_calc #(.WIN_W(WIN_W), .DEPTH(OBS_DEPTH), .CNT_W(CNT_W)) u_win (
    .req(wreq_q), .tol(tol_q), .moves(w_up != w_dn), .win(win_next)
  );

  tsx_scan_timer #(.SCAN_W(SCAN_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(step_issue), .run(phase_q == PH_OBSERVE),
    .scan_len(slen_q), .win(win_q), .sample_ev(sample_ev), .last_ev(last_ev),
    .scan_idx(scan_idx)
  );

  tsx_obs_buffer #(.OUT_W(OUT_W), .DEPTH(OBS_DEPTH), .IDX_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(step_issue), .wr_en(sample_ev),
    .wr_idx(scan_idx), .wr_data(dut_out), .flat(chk_obs)
  );

  assign step_addr = idx_q[ADDR_W-1:0];
  assign chk_valid = (phase_q == PH_VERDICT);
  assign busy      = (phase_q == PH_LOAD) || (phase_q == PH_OBSERVE) || (phase_q == PH_VERDICT);
  assign chk_count = win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      idx_q       <= '0;
      num_q       <= '0;
      prev_down_q <= '0;
      slen_q      <= '0;
      wreq_q      <= '0;
      tol_q       <= 1'b0;
      win_q       <= '0;
      dut_in      <= '0;
      chk_prev_in <= '0;
      chk_up      <= '0;
      chk_in      <= '0;
      chk_down    <= '0;
      chk_exp     <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
      chain_err   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE, PH_END: begin
          if (start_take) begin
            num_q       <= num_steps;
            slen_q      <= scan_len;
            wreq_q      <= win_scans;
            tol_q       <= tolerant;
            prev_down_q <= init_state;
            idx_q       <= '0;
            fail        <= 1'b0;
            chain_err   <= 1'b0;
            done        <= (num_steps == '0);
            phase_q     <= (num_steps == '0) ? PH_END : PH_LOAD;
          end
        end
        PH_LOAD: begin
          if (chain_bad) begin
            chain_err <= 1'b1;
            fail      <= 1'b1;
            done      <= 1'b1;
            phase_q   <= PH_END;
          end else begin
            chk_prev_in <= dut_in;
            dut_in      <= w_in;
            chk_up      <= w_up;
            chk_in      <= w_in;
            chk_down    <= w_dn;
            chk_exp     <= w_exp;
            win_q       <= win_next;
            phase_q     <= PH_OBSERVE;
          end
        end
        PH_OBSERVE: begin
          if (last_ev) phase_q <= PH_VERDICT;
        end
        PH_VERDICT: begin
          if (verdict_take) begin
            if (!vrd_pass) begin
              fail    <= 1'b1;
              done    <= 1'b1;
              phase_q <= PH_END;
            end else begin
              prev_down_q <= chk_down;
              if (idx_q == num_q - 1'b1) begin
                done    <= 1'b1;
                phase_q <= PH_END;
              end else begin
                idx_q   <= idx_q + 1'b1;
                phase_q <= PH_LOAD;
              end
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tsx_step_player_chk.sv
module tsx_step_player_chk #(
  parameter int IN_W      = 4,
  parameter int OUT_W     = 3,
  parameter int OBS_DEPTH = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [IN_W-1:0]                dut_in,
  input logic                           chk_valid,
  input logic [OBS_DEPTH*OUT_W-1:0]     chk_obs,
  input logic [$clog2(OBS_DEPTH+1)-1:0] chk_count,
  input logic                           vrd_valid,
  input logic                           busy,
  input logic                           done,
  input logic                           fail,
  input logic                           chain_err,
  input logic                           step_issue,
  input logic                           chain_bad,
  input logic                           last_ev
);

  // R3
  inputs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_issue |=> $stable(dut_in));

  // R6
  handoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !vrd_valid |=> chk_valid && $stable(chk_obs));

  // R6
  handoff_follows_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> chk_valid);

  // R4
  window_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> chk_count >= 2);

  // R7
  chain_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_bad |=> chain_err && fail && done && !busy && $stable(dut_in));

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  fail_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

endmodule

bind tsx_step_player tsx_step_player_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .OBS_DEPTH(OBS_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dut_in(dut_in), .chk_valid(chk_valid),
  .chk_obs(chk_obs), .chk_count(chk_count), .vrd_valid(vrd_valid),
  .busy(busy), .done(done), .fail(fail), .chain_err(chain_err),
  .step_issue(step_issue), .chain_bad(chain_bad), .last_ev(last_ev)
);

// File: tb/sim_tsx_step_player.sv
module sim_tsx_step_player;
  localparam int IN_W = 4, OUT_W = 3, ST_W = 3, ADDR_W = 4, DEPTH = 6, SCAN_W = 4, WIN_W = 4;
  localparam int STEP_W = 2*ST_W + IN_W + OUT_W;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, tolerant = 1'b0, vrd_valid = 1'b0, vrd_pass = 1'b0;
  logic [ADDR_W:0] num_steps = '0;
  logic [ST_W-1:0] init_state = '0;
  logic [SCAN_W-1:0] scan_len = '0;
  logic [WIN_W-1:0] win_scans = '0;
  logic [ADDR_W-1:0] step_addr;
  logic [STEP_W-1:0] step_word;
  logic [IN_W-1:0] dut_in, chk_in, chk_prev_in;
  logic [OUT_W-1:0] dut_out = '0, chk_exp;
  logic [ST_W-1:0] chk_up, chk_down;
  logic chk_valid, busy, done, fail, chain_err;
  logic [DEPTH*OUT_W-1:0] chk_obs;
  logic [CNT_W-1:0] chk_count;
  logic [STEP_W-1:0] mem [16];

  assign step_word = mem[step_addr];

  tsx_step_player #(.IN_W(IN_W), .OUT_W(OUT_W), .ST_W(ST_W), .ADDR_W(ADDR_W),
    .OBS_DEPTH(DEPTH), .SCAN_W(SCAN_W), .WIN_W(WIN_W)) u0 (.*);

  int checks = 0, errors = 0, cyc = 0, fail_at = -1, wait_ct = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [STEP_W-1:0] mk(int u, int i, int d, int e);
    return {ST_W'(u), IN_W'(i), ST_W'(d), OUT_W'(e)};
  endfunction

  function automatic int ref_window(int req, bit t, bit mv);
    int f, w;
    f = 2;
    if (mv) f = 3;
    if (t) f = 4;
    w = (req < f) ? f : req;
    if (w > DEPTH) w = DEPTH;
    return w;
  endfunction

  // Behavioural reference model: 0 idle, 1 fetch, 2 window, 3 verdict wait, 4 finished
  int ph = 0, m_idx, m_num, m_prev, m_slen, m_req, m_win, m_tick, m_scan;
  int m_din = 0, m_pin = 0, m_u, m_i, m_d, m_e;
  bit m_tol, m_done = 0, m_fail = 0, m_cerr = 0;
  int m_obs[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_din = 0; m_pin = 0; m_done = 0; m_fail = 0; m_cerr = 0;
    end else begin
      case (ph)
        0, 4: if (start) begin
          m_num = int'(num_steps); m_slen = (scan_len == 0) ? 1 : int'(scan_len);
          m_req = int'(win_scans); m_tol = tolerant; m_prev = int'(init_state);
          m_idx = 0; m_fail = 0; m_cerr = 0; m_done = (m_num == 0);
          ph = (m_num == 0) ? 4 : 1;
        end
        1: begin
          m_u = int'(mem[m_idx][STEP_W-1 -: ST_W]);
          m_i = int'(mem[m_idx][OUT_W+ST_W +: IN_W]);
          m_d = int'(mem[m_idx][OUT_W +: ST_W]);
          m_e = int'(mem[m_idx][0 +: OUT_W]);
          if (m_u != m_prev) begin
            m_cerr = 1; m_fail = 1; m_done = 1; ph = 4;
          end else begin
            m_pin = m_din; m_din = m_i;
            m_win = ref_window(m_req, m_tol, m_u != m_d);
            m_obs.delete(); m_tick = 0; m_scan = 0; ph = 2;
          end
        end
        2: begin
          m_tick++;
          if (m_tick == m_slen) begin
            m_obs.push_back(int'(dut_out)); m_tick = 0; m_scan++;
            if (m_scan == m_win) ph = 3;
          end
        end
        3: if (vrd_valid) begin
          if (!vrd_pass) begin m_fail = 1; m_done = 1; ph = 4; end
          else begin
            m_prev = m_d;
            if (m_idx == m_num - 1) begin m_done = 1; ph = 4; end
            else begin m_idx++; ph = 1; end
          end
        end
        default: ph = 0;
      endcase
    end
  end

  // Compare on every clock, then drive the controller output and the verdict
  always @(negedge clk) begin
    if (rst_n) begin
      logic [DEPTH*OUT_W-1:0] ef;
      check("R2 R12 busy", busy, (ph >= 1 && ph <= 3));
      check("R8 R10 done", done, m_done);
      check("R9 fail", fail, m_fail);
      check("R7 chain_err", chain_err, m_cerr);
      check("R6 chk_valid", chk_valid, ph == 3);
      check("R3 R7 dut_in", dut_in, m_din);
      if (ph == 1) check("R2 step_addr", step_addr, m_idx);
      if (ph == 3) begin
        ef = '0;
        foreach (m_obs[k]) ef[k*OUT_W +: OUT_W] = OUT_W'(m_obs[k]);
        check("R4 chk_count", chk_count, m_win);
        check("R5 chk_obs", chk_obs, ef);
        check("R6 context", {chk_up, chk_in, chk_down, chk_exp}, {ST_W'(m_u), IN_W'(m_i), ST_W'(m_d), OUT_W'(m_e)});
        check("R11 chk_prev_in", chk_prev_in, m_pin);
      end
    end
    cyc++;
    dut_out = OUT_W'(cyc * 5 + int'(dut_in));
    if (vrd_valid) vrd_valid = 1'b0;
    else if (ph == 3) begin
      wait_ct++;
      if (wait_ct >= 3) begin
        vrd_valid = 1'b1; vrd_pass = (m_idx != fail_at); wait_ct = 0;
      end
    end
  end

  task automatic run(bit poke_mid);
    int n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke_mid) begin
      repeat (6) @(negedge clk);
      start = 1'b1;  // R12: ignored while busy
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (ph != 4 && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) begin errors++; $display("FAIL R8 run did not finish actual=busy expected=done"); end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dut_in", dut_in, 0);
    check("R1 flags", {busy, done, fail, chain_err, chk_valid}, 0);

    // A: move, self-loop, move; window raised to the floor; restart attempt mid-run
    mem[0] = mk(1, 4'h3, 2, 5); mem[1] = mk(2, 4'hA, 2, 5); mem[2] = mk(2, 4'h6, 5, 1);
    num_steps = 3; init_state = 1; scan_len = 3; win_scans = 1; tolerant = 0; fail_at = -1;
    run(1);
    check("R8 pass ends clean", {done, fail}, 2'b10);

    // B: tolerant mode lengthens the window to four scans
    mem[0] = mk(2, 4'hF, 2, 6); mem[1] = mk(2, 4'h0, 7, 3);
    num_steps = 2; init_state = 2; scan_len = 2; win_scans = 2; tolerant = 1;
    run(0);

    // C: oversized request capped at the buffer depth, one-clock scans
    scan_len = 1; win_scans = 9; tolerant = 0;
    run(0);

    // D: chaining mismatch on the second step
    mem[0] = mk(1, 4'h1, 3, 0); mem[1] = mk(4, 4'h2, 4, 0);
    num_steps = 2; init_state = 1; scan_len = 2; win_scans = 2;
    run(0);
    check("R7 chain stop", {chain_err, fail, done}, 3'b111);

    // E: negative verdict on step 1, scan length zero acts as one
    mem[0] = mk(1, 4'h3, 2, 5); mem[1] = mk(2, 4'hA, 2, 5); mem[2] = mk(2, 4'h6, 5, 1);
    num_steps = 3; init_state = 1; scan_len = 0; win_scans = 3; fail_at = 1;
    run(0);
    check("R9 fail stop", {chain_err, fail, done}, 3'b011);

    // F: first step does not start from the initial state
    fail_at = -1; init_state = 6;
    run(0);
    check("R7 first step chain", chain_err, 1);

    // G: empty run
    num_steps = 0;
    run(0);
    check("R10 empty run", {done, fail, busy}, 3'b100);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule